// File: doc/BRIEF.md
# Dual-Mode Host Parallel Bus Interface

This block connects a host processor's parallel bus to a bank of 8-bit registers inside a larger device. Two static strap inputs pick the bus personality. `strap_shared` chooses between separate address and data lines and a single shared address/data bus. `strap_dirstb` chooses between split strobes (separate read and write strobes, with an address-latch pulse) and direction-strobe signalling (one data strobe, a read/write direction line and an address strobe). That gives four personalities on one set of pins.

All host control, address and data pins pass through a two-stage synchronizer into the internal clock `clk`. A state machine then decodes chip select and the strobes. Its states are IDLE, RD_START, RD_HOLD, WR_HOLD and WR_COMMIT, with these transitions:
- IDLE goes to WR_HOLD when a selected write strobe is seen, or to RD_START when a selected read strobe is seen. A write wins if both are present.
- RD_START goes to RD_HOLD while the selected read continues, and otherwise back to IDLE.
- RD_HOLD stays while the read continues, and otherwise returns to IDLE.
- WR_HOLD returns to IDLE if the host deselects (an abort). It goes to WR_COMMIT when the write strobe ends while the host is still selected, and otherwise stays.
- WR_COMMIT always goes to IDLE.

The block gives the register bank an address, write data, a one-cycle write enable and a one-cycle read enable. It returns read data on a data bus with a separate output enable. It also drives an open-drain interrupt pin from a request input. A test input releases every output the block drives toward the host.

Top module: `hpbus_if`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `reg_re`, `reg_we`, `host_doe` and `host_irq_drv` are 0 and `reg_addr` and `reg_wdata` are 0.
- R2: While `host_sel_n` is high, no read or write starts: `reg_re` and `reg_we` stay 0 and the register contents are unchanged.
- R3: With `strap_dirstb`=0, `host_dstb` low is a read and `host_dir` low is a write. A write commits as a single-cycle `reg_we` once `host_dir` has returned high while `host_sel_n` is still low. `reg_wdata` is the last `host_din` value seen while `host_dir` was low.
- R4: With `strap_dirstb`=1, `host_dstb` is a data strobe. It is active low when `strap_shared`=1 and active high when `strap_shared`=0. `host_dir`=1 marks a read and 0 marks a write. A write commits as a single-cycle `reg_we` at the end of the data strobe.
- R5: With `strap_shared`=0, the register address is `{host_lat, host_alo[6:0]}`, so `host_lat` is address bit 7.
- R6: With `strap_shared`=1, the address is taken from `host_din[7:0]` on each rising edge of `host_lat`, in both strobe styles. `host_alo` is ignored.
- R7: If `host_sel_n` rises while a write strobe is still active, the write is dropped and no `reg_we` is issued.
- R8: A read gives `reg_re` for exactly one cycle at its start. `host_doe` is then high for as long as the selected read strobe lasts, with `host_dout` equal to `reg_rdata` for the held `reg_addr`.
- R9: While `force_hiz` is 1, `host_doe` and `host_irq_drv` are 0 in the same cycle.
- R10: `host_irq_drv` (1 pulls the open-drain interrupt pin low) equals `irq_req` delayed by one clock.
- R11: A host pin level present at one rising edge of `clk` reaches the state machine at the second edge after it. The resulting state change is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_shared | input | 1 | 1: shared address/data bus; 0: separate buses |
| strap_dirstb | input | 1 | 1: direction-strobe style; 0: split-strobe style |
| force_hiz | input | 1 | 1 releases host data bus and interrupt drive |
| host_sel_n | input | 1 | Chip select, active low |
| host_dstb | input | 1 | Read strobe (split style) or data strobe (direction style) |
| host_dir | input | 1 | Write strobe, active low (split style) or read/write direction (direction style) |
| host_lat | input | 1 | Address latch/strobe (shared bus) or address bit 7 (separate buses) |
| host_alo | input | 7 | Address bits 6..0 (separate buses only) |
| host_din | input | 8 | Host data, or address during the latch phase |
| host_dout | output | 8 | Read data toward the host |
| host_doe | output | 1 | Output enable for host_dout |
| irq_req | input | 1 | Interrupt request from status logic |
| host_irq_drv | output | 1 | 1 pulls the open-drain interrupt pin low |
| reg_re | output | 1 | Register read enable, one cycle |
| reg_we | output | 1 | Register write enable, one cycle |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
The assertions watch properties that hold in every cycle:
- enables are one cycle wide;
- a commit always follows a write phase;
- a deselected idle state never starts an access;
- the address is held through an access;
- the address latch moves only in shared-bus mode.

Other behaviour depends on the bench's scenarios and its cycle-by-cycle reference model. This covers how each of the four personalities forms addresses and strobe polarities, which data word a write captures, aborted and unselected writes, read-back values, the test release and the interrupt delay.

// File: rtl/hpbus_pkg.sv
package hpbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_START,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_WR_COMMIT
    } bus_state_e;

    // Host strobes after mode decoding, all active high
    typedef struct packed {
        logic sel;
        logic rd_stb;
        logic wr_stb;
        logic wr_hold;
    } bus_ctl_t;

endpackage

// File: rtl/hpbus_sync.sv
module hpbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hpbus_decode.sv
module hpbus_decode
    import hpbus_pkg::*;
(
    input  logic     strap_shared,
    input  logic     strap_dirstb,
    input  logic     sel_n,
    input  logic     dstb,
    input  logic     dir,
    output bus_ctl_t ctl
);

    logic ds_act;

    // Data strobe polarity depends on bus sharing
    assign ds_act = strap_shared ? ~dstb : dstb;

    always_comb begin
        ctl.sel = ~sel_n;
        if (strap_dirstb) begin
            ctl.rd_stb  = ds_act & dir;
            ctl.wr_stb  = ds_act & ~dir;
            ctl.wr_hold = ds_act;
        end else begin
            ctl.rd_stb  = ~dstb;
            ctl.wr_stb  = ~dir;
            ctl.wr_hold = ~dir;
        end
    end

endmodule

// File: rtl/hpbus_fsm.sv
module hpbus_fsm
    import hpbus_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_ctl_t      ctl,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] wdata_in,
    output logic          reg_re,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          rd_drive
);

    bus_state_e    st, st_nxt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          start_wr, start_rd, hold_wr;

    assign start_wr = (st == ST_IDLE) && ctl.sel && ctl.wr_stb;
    assign start_rd = (st == ST_IDLE) && ctl.sel && ctl.rd_stb && !ctl.wr_stb;
    assign hold_wr  = (st == ST_WR_HOLD) && ctl.sel && ctl.wr_hold;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (start_wr)      st_nxt = ST_WR_HOLD;
                else if (start_rd) st_nxt = ST_RD_START;
            end
            ST_RD_START,
            ST_RD_HOLD: begin
                st_nxt = (ctl.sel && ctl.rd_stb) ? ST_RD_HOLD : ST_IDLE;
            end
            ST_WR_HOLD: begin
                if (!ctl.sel)          st_nxt = ST_IDLE;
                else if (!ctl.wr_hold) st_nxt = ST_WR_COMMIT;
            end
            ST_WR_COMMIT: st_nxt = ST_IDLE;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // Address and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (start_wr || start_rd) addr_q  <= cur_addr;
            if (start_wr || hold_wr)  wdata_q <= wdata_in;
        end
    end

    // Outputs
    always_comb begin
        reg_re    = (st == ST_RD_START);
        reg_we    = (st == ST_WR_COMMIT);
        rd_drive  = (st == ST_RD_START) || (st == ST_RD_HOLD);
        reg_addr  = addr_q;
        reg_wdata = wdata_q;
    end

    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_commit_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(st) == ST_WR_HOLD);

    assert_re_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    assert_no_start_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ctl.sel) |=> (st == ST_IDLE));

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(addr_q));

endmodule

// File: rtl/hpbus_if.sv
module hpbus_if
    import hpbus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_LO_W   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_shared,
    input  logic                 strap_dirstb,
    input  logic                 force_hiz,
    input  logic                 host_sel_n,
    input  logic                 host_dstb,
    input  logic                 host_dir,
    input  logic                 host_lat,
    input  logic [ADDR_LO_W-1:0] host_alo,
    input  logic [DATA_W-1:0]    host_din,
    output logic [DATA_W-1:0]    host_dout,
    output logic                 host_doe,
    input  logic                 irq_req,
    output logic                 host_irq_drv,
    output logic                 reg_re,
    output logic                 reg_we,
    output logic [ADDR_LO_W:0]   reg_addr,
    output logic [DATA_W-1:0]    reg_wdata,
    input  logic [DATA_W-1:0]    reg_rdata
);

    localparam int REG_AW = ADDR_LO_W + 1;
    localparam int PIN_W  = 4 + ADDR_LO_W + DATA_W;

    logic [PIN_W-1:0]     pin_raw, pin_s;
    logic                 sel_n_s, dstb_s, dir_s, lat_s;
    logic [ADDR_LO_W-1:0] alo_s;
    logic [DATA_W-1:0]    din_s;
    logic                 lat_prev, lat_rise;
    logic [REG_AW-1:0]    alat_q, cur_addr;
    logic                 irq_q, rd_drive;
    bus_ctl_t             ctl;

    assign pin_raw = {host_sel_n, host_dstb, host_dir, host_lat, host_alo, host_din};

    hpbus_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_s)
    );

    assign sel_n_s = pin_s[PIN_W-1];
    assign dstb_s  = pin_s[PIN_W-2];
    assign dir_s   = pin_s[PIN_W-3];
    assign lat_s   = pin_s[PIN_W-4];
    assign alo_s   = pin_s[DATA_W +: ADDR_LO_W];
    assign din_s   = pin_s[DATA_W-1:0];

    hpbus_decode u_decode (
        .strap_shared (strap_shared),
        .strap_dirstb (strap_dirstb),
        .sel_n        (sel_n_s),
        .dstb         (dstb_s),
        .dir          (dir_s),
        .ctl          (ctl)
    );

    // Address latch for the shared bus, loaded on a rising latch strobe
    assign lat_rise = strap_shared && lat_s && !lat_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_prev <= 1'b1;
            alat_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            lat_prev <= lat_s;
            irq_q    <= irq_req;
            if (lat_rise) alat_q <= din_s[REG_AW-1:0];
        end
    end

    assign cur_addr = strap_shared ? alat_q : {lat_s, alo_s};

    hpbus_fsm #(
        .AW (REG_AW),
        .DW (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .cur_addr  (cur_addr),
        .wdata_in  (din_s),
        .reg_re    (reg_re),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_drive  (rd_drive)
    );

    assign host_doe     = rd_drive && !force_hiz;
    assign host_dout    = rd_drive ? reg_rdata : '0;
    assign host_irq_drv = irq_q && !force_hiz;

    assert_latch_shared_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_shared |=> $stable(alat_q));

endmodule

// File: tb/hpbus_if_tb.sv
`timescale 1ns/1ps
module hpbus_if_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_shared = 1'b0, strap_dirstb = 1'b0, force_hiz = 1'b0;
    logic       host_sel_n = 1'b1, host_dstb = 1'b1, host_dir = 1'b1, host_lat = 1'b0;
    logic [6:0] host_alo = '0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_doe, irq_req = 1'b0, host_irq_drv;
    logic       reg_re, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit shared_m = 0, dirstb_m = 0;

    logic [7:0] arr     [256];
    logic [7:0] exp_arr [256];

    always #2.5 clk = ~clk;

    hpbus_if u_dut (
        .clk (clk), .rst_n (rst_n),
        .strap_shared (strap_shared), .strap_dirstb (strap_dirstb), .force_hiz (force_hiz),
        .host_sel_n (host_sel_n), .host_dstb (host_dstb), .host_dir (host_dir),
        .host_lat (host_lat), .host_alo (host_alo), .host_din (host_din),
        .host_dout (host_dout), .host_doe (host_doe),
        .irq_req (irq_req), .host_irq_drv (host_irq_drv),
        .reg_re (reg_re), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
    );

    // Register bank stand-in, driven only through the block's ports
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) arr[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_we) begin
            arr[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = arr[reg_addr];

    // Behavioural reference model: pin history queue plus access tracker
    logic [18:0] pin_q [$];
    int          m_st;
    logic [7:0]  m_addr, m_wd, m_alat;
    logic        m_lprev, m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   = {19'h7FFFF, 19'h7FFFF};
            m_st    = 0;
            m_addr  = 0;
            m_wd    = 0;
            m_alat  = 0;
            m_lprev = 1;
            m_irq   = 0;
        end else begin
            logic [18:0] p;
            logic sel, ds, rds, wrs, whold;
            logic [7:0] a_now;
            p   = pin_q.pop_front();
            sel = !p[18];
            if (dirstb_m) begin
                ds    = shared_m ? !p[17] : p[17];
                rds   = ds && p[16];
                wrs   = ds && !p[16];
                whold = ds;
            end else begin
                rds   = !p[17];
                wrs   = !p[16];
                whold = !p[16];
            end
            a_now = shared_m ? m_alat : {p[15], p[14:8]};
            case (m_st)
                0: if (sel && wrs) begin m_st = 3; m_addr = a_now; m_wd = p[7:0]; end
                   else if (sel && rds) begin m_st = 1; m_addr = a_now; end
                1, 2: m_st = (sel && rds) ? 2 : 0;
                3: if (!sel) m_st = 0;
                   else if (!whold) m_st = 4;
                   else m_wd = p[7:0];
                default: m_st = 0;
            endcase
            if (shared_m && p[15] && !m_lprev) m_alat = p[7:0];
            m_lprev = p[15];
            m_irq   = irq_req;
            pin_q.push_back({host_sel_n, host_dstb, host_dir, host_lat, host_alo, host_din});
        end
    end

    // R11: every clock, all outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_oe;
            e_oe = (m_st == 1 || m_st == 2) && !force_hiz;
            checks++;
            if (reg_re !== (m_st == 1) || reg_we !== (m_st == 4) || host_doe !== e_oe ||
                reg_addr !== m_addr || reg_wdata !== m_wd ||
                host_irq_drv !== (m_irq && !force_hiz) ||
                (e_oe && host_dout !== arr[m_addr])) begin
                errors++;
                $display("FAIL R11 model mismatch t=%0t actual re=%b we=%b oe=%b a=%h wd=%h irq=%b expected re=%b we=%b oe=%b a=%h wd=%h irq=%b",
                    $time, reg_re, reg_we, host_doe, reg_addr, reg_wdata, host_irq_drv,
                    (m_st == 1), (m_st == 4), e_oe, m_addr, m_wd, (m_irq && !force_hiz));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pins_idle();
        host_sel_n = 1;
        host_dstb  = (dirstb_m && !shared_m) ? 1'b0 : 1'b1;
        host_dir   = 1;
        host_lat   = 0;
        host_alo   = '0;
        host_din   = '0;
    endtask

    task automatic put_addr(input logic [7:0] a);
        if (shared_m) begin
            host_alo = ~a[6:0];
            host_din = a;
            host_lat = 1;
            step(3);
            host_lat = 0;
            step(1);
        end else begin
            host_lat = a[7];
            host_alo = a[6:0];
        end
    endtask

    task automatic strobe(input logic on, input logic wr);
        if (dirstb_m) begin
            if (on) begin
                host_dir = !wr;
                step(1);
                host_dstb = shared_m ? 1'b0 : 1'b1;
            end else begin
                host_dstb = shared_m ? 1'b1 : 1'b0;
            end
        end else begin
            if (on) begin
                if (wr) host_dir = 0; else host_dstb = 0;
            end else begin
                host_dstb = 1;
                host_dir  = 1;
            end
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d,
                              input bit use_sel, input bit abort);
        put_addr(a);
        host_din   = d;
        host_sel_n = !use_sel;
        step(1);
        strobe(1, 1);
        step(4);
        if (abort) begin host_sel_n = 1; step(3); end
        strobe(0, 1);
        step(3);
        pins_idle();
        step(4);
        if (use_sel && !abort) exp_arr[a] = d;
    endtask

    task automatic host_read(input logic [7:0] a, input string tag, input bit hiz_probe);
        put_addr(a);
        host_din   = '0;
        host_sel_n = 0;
        step(1);
        strobe(1, 0);
        step(4);
        chk({tag, " R8 output enable during read"}, host_doe, 1'b1);
        chk({tag, " R8 read data"}, host_dout, exp_arr[a]);
        if (hiz_probe) begin
            force_hiz = 1;
            #1;
            chk("R9 data bus released", host_doe, 1'b0);
            force_hiz = 0;
        end
        strobe(0, 0);
        step(3);
        pins_idle();
        step(4);
    endtask

    task automatic do_reset(input bit sh, input bit ds);
        rst_n = 0;
        shared_m = sh; dirstb_m = ds;
        strap_shared = sh; strap_dirstb = ds;
        force_hiz = 0; irq_req = 0;
        pins_idle();
        for (int i = 0; i < 256; i++) exp_arr[i] = 8'(i) ^ 8'h5A;
        step(3);
        rst_n = 1;
        step(1);
        chk("R1 reset re/we/oe/irq", {reg_re, reg_we, host_doe, host_irq_drv}, 4'b0000);
        chk("R1 reset addr/wdata", {reg_addr, reg_wdata}, 16'h0000);
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            string tg;
            do_reset(m[0], m[1]);
            tg = {m[1] ? "R4" : "R3", m[0] ? " R6" : " R5"};
            host_write(8'h00, 8'hA1 ^ 8'(m), 1, 0);
            host_write(8'hFF, 8'h3C ^ 8'(m), 1, 0);
            host_write(8'h80, 8'h96 ^ 8'(m), 1, 0);
            host_write(8'h7F, 8'h0F ^ 8'(m), 1, 0);
            chk({tg, " write 00"}, arr[8'h00], exp_arr[8'h00]);
            chk({tg, " write FF"}, arr[8'hFF], exp_arr[8'hFF]);
            chk({tg, " write 80 (bit 7)"}, arr[8'h80], exp_arr[8'h80]);
            chk({tg, " write 7F"}, arr[8'h7F], exp_arr[8'h7F]);
            host_read(8'h80, tg, 0);
            host_read(8'h7F, tg, 0);
            host_read(8'h12, tg, m == 2);
            host_write(8'h33, 8'hEE, 1, 1);
            chk("R7 aborted write leaves register", arr[8'h33], exp_arr[8'h33]);
            host_read(8'h33, "R7", 0);
            host_write(8'h44, 8'h11, 0, 0);
            chk("R2 unselected write leaves register", arr[8'h44], exp_arr[8'h44]);
        end
        irq_req = 1;
        step(2);
        chk("R10 interrupt drive follows request", host_irq_drv, 1'b1);
        force_hiz = 1;
        #1;
        chk("R9 interrupt released in test", host_irq_drv, 1'b0);
        force_hiz = 0;
        irq_req = 0;
        step(2);
        chk("R10 interrupt drive drops", host_irq_drv, 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule